// File: doc/BRIEF.md
# Bus Breakpoint and Single-Step Controller

This block sits in the glue logic that ends each CPU bus cycle. It decodes the chip selects for RAM and ROM and produces the cycle acknowledge. It also compares every program fetch against a breakpoint address that is loaded at run time. When a fetch matches, the block takes one of three actions. It can hold the bus and release one acknowledge per debounced button press. It can complete the fetch with an illegal-instruction opcode it drives itself, while both memories stay deselected. Or it can end the cycle with a bus error instead of an acknowledge.

After reset, the low address range maps onto ROM so that the CPU reads its first stack pointer and reset vector from ROM. This overlay clears on the first access to the normal ROM region. When a trap or bus-error breakpoint fires, the block turns the overlay back on with a debug ROM bank selected. The exception vector fetch that follows then reads a custom handler address. Because the CPU prefetches, a match only marks the breakpoint as pending. The breakpoint counts as confirmed only when a later supervisor data read of the matching exception vector is seen. A clear input returns the block to normal running.

Top module: `bus_bp_ctrl`

## Requirements
- R1: After reset the overlay is on, the debug bank is off, no acknowledge or bus error is driven, and the pending, confirmed and step-hold flags read 0 with reported mode 0.
- R2: A cycle that causes no breakpoint action gets exactly one acknowledge pulse of one clock, one clock after the request is first seen. RAM and ROM selects are never both high. Top address nibble below 4 selects RAM and nibble 4 selects ROM.
- R3: While the overlay is on, accesses with top nibble 0 select ROM. The first access with top nibble 4 turns the overlay and the debug bank off, after which nibble 0 selects RAM.
- R4: A breakpoint match needs the access address to equal the value captured on the last load strobe, function code bit 1 high and bit 0 low (a program fetch), and mode not 0. Data accesses to the same address act as normal cycles and leave the pending flag at 0.
- R5: Mode 1 (step): a matching fetch sets the step-hold flag. From then on, every bus cycle gets no acknowledge until a step press arrives, and each press releases exactly one acknowledge.
- R6: A step press while no cycle is being held produces no acknowledge and changes no flag.
- R7: Mode 2 (trap): a matching fetch is acknowledged with data drive high and opcode 0x4AFC on the data output, and with RAM and ROM selects low.
- R8: Mode 3 (bus error): a matching fetch gets a one-clock bus error, no acknowledge and no memory select. There is no halt request, so the CPU does not retry the cycle.
- R9: A trap or bus-error match sets the pending flag and turns the overlay on with the debug bank selected. A low-range vector read then selects ROM with the bank output high.
- R10: A pending breakpoint becomes confirmed (confirmed 1, pending 0) only on a supervisor data read (function code 101, read) of address 0x000010 in trap mode or 0x000008 in bus-error mode. Other reads leave it pending.
- R11: A clear pulse returns pending, confirmed, step-hold, mode, overlay and debug bank to 0, and releases a held cycle with one acknowledge.
- R12: The mode output reports the mode latched at the match (1 step, 2 trap, 3 bus error) until cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Bus cycle in progress, held until acknowledge or bus error |
| busWrite | input | 1 | Cycle is a write |
| busAddr | input | AW | Cycle address |
| funcCode | input | 3 | CPU function code |
| bpLoad | input | 1 | Strobe that captures the breakpoint address |
| bpAddrIn | input | AW | Breakpoint address from switches or controller |
| bpMode | input | 2 | Action on match: 0 off, 1 step, 2 trap, 3 bus error |
| stepPress | input | 1 | Debounced step button pulse |
| clearDbg | input | 1 | Return to normal running |
| cycleAck | output | 1 | Cycle acknowledge pulse |
| busErr | output | 1 | Bus error pulse |
| ramSel | output | 1 | RAM chip select |
| romSel | output | 1 | ROM chip select |
| romBank | output | 1 | Debug ROM bank select |
| dataDrive | output | 1 | Block drives the data bus |
| dataOut | output | DW | Injected opcode |
| matchPending | output | 1 | Breakpoint matched, not yet confirmed |
| hitConfirmed | output | 1 | Exception vector read observed |
| stepHold | output | 1 | Single-step hold active |
| overlayOn | output | 1 | ROM overlay at low addresses |
| activeMode | output | 2 | Mode latched at the match |

## Verification
If the cycle state is wrong, the fault shows at once at the bus pins. Either a cycle never sees an acknowledge, which hangs the CPU and trips the bench's per-cycle timeout, or an acknowledge appears that no expected item accounts for. If the overlay or bank flag is wrong, the very next low-range access shows up with a wrong select or bank value. If the pending or confirmed flag is wrong, the status pins show it right after the vector read, and the next clear does not bring them back to zero.

// File: rtl/bus_bp_pkg.sv
`timescale 1ns/1ps
package bus_bp_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_STEP = 2'd1,
    MODE_TRAP = 2'd2,
    MODE_BERR = 2'd3
  } bpMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACK,
    ST_BERR,
    ST_DONE
  } busSt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchSel;     // register memory selects for this cycle
    logic latchInject;  // deselect memories, drive opcode
    logic dropSel;      // end of cycle: release selects and data
  } dpStrobe_t;
endpackage

// File: rtl/bus_bp_dp.sv
`timescale 1ns/1ps
module bus_bp_dp
  import bus_bp_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int ROM_NIB = 4,
  parameter logic [DW-1:0] TRAP_OPCODE = 16'h4AFC
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic [1:0]    fcLow,
  input  logic          bpLoad,
  input  logic [AW-1:0] bpAddrIn,
  input  logic          overlayOn,
  input  dpStrobe_t     strobe,
  output logic          fetchHit,
  output logic          romRegion,
  output logic          ramSel,
  output logic          romSel,
  output logic          dataDrive,
  output logic [DW-1:0] dataOut
);
  localparam int NIBW = 4;

  logic [AW-1:0]   bpReg;
  logic [NIBW-1:0] topNib;
  logic            wantRom;
  logic            wantRam;
  logic            ramQ, romQ, driveQ;

  assign topNib    = busAddr[AW-1 -: NIBW];
  assign romRegion = (topNib == NIBW'(ROM_NIB));
  assign wantRom   = romRegion || (overlayOn && topNib == '0);
  assign wantRam   = !wantRom && (topNib < NIBW'(ROM_NIB));
  assign fetchHit  = (busAddr == bpReg) && fcLow[1] && !fcLow[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bpReg <= '0;
    end else if (bpLoad) begin
      bpReg <= bpAddrIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramQ   <= 1'b0;
      romQ   <= 1'b0;
      driveQ <= 1'b0;
    end else if (strobe.dropSel) begin
      ramQ   <= 1'b0;
      romQ   <= 1'b0;
      driveQ <= 1'b0;
    end else if (strobe.latchInject) begin
      ramQ   <= 1'b0;
      romQ   <= 1'b0;
      driveQ <= 1'b1;
    end else if (strobe.latchSel) begin
      ramQ   <= wantRam;
      romQ   <= wantRom;
      driveQ <= 1'b0;
    end
  end

  assign ramSel    = ramQ;
  assign romSel    = romQ;
  assign dataDrive = driveQ;
  assign dataOut   = driveQ ? TRAP_OPCODE : '0;
endmodule

// File: rtl/bus_bp_ctl.sv
`timescale 1ns/1ps
module bus_bp_ctl
  import bus_bp_pkg::*;
#(
  parameter int AW = 24,
  parameter int TRAP_VEC = 4,
  parameter int BERR_VEC = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busReq,
  input  logic          busWrite,
  input  logic [2:0]    funcCode,
  input  logic [AW-1:0] busAddr,
  input  logic          fetchHit,
  input  logic          romRegion,
  input  logic [1:0]    bpMode,
  input  logic          stepPress,
  input  logic          clearDbg,
  output dpStrobe_t     strobe,
  output logic          cycleAck,
  output logic          busErr,
  output logic          matchPending,
  output logic          hitConfirmed,
  output logic          stepHold,
  output logic          overlayOn,
  output logic          romBank,
  output logic [1:0]    activeMode
);
  localparam int TRAP_VEC_ADDR = TRAP_VEC * 4;
  localparam int BERR_VEC_ADDR = BERR_VEC * 4;
  localparam logic [2:0] FC_SUP_DATA = 3'b101;

  busSt_e      st, stNxt;
  logic        pendQ, confQ, holdQ, ovlQ, bankQ;
  logic [1:0]  modeQ;
  logic        armedHit;
  logic        vecRead;
  logic [AW-1:0] vecAddr;

  assign armedHit = fetchHit && (bpMode != MODE_OFF) && !holdQ;
  assign vecAddr  = (modeQ == MODE_BERR) ? AW'(BERR_VEC_ADDR) : AW'(TRAP_VEC_ADDR);
  assign vecRead  = (funcCode == FC_SUP_DATA) && !busWrite && (busAddr == vecAddr);

  always_comb begin
    stNxt  = st;
    strobe = '0;
    case (st)
      ST_IDLE: if (busReq) begin
        if (holdQ || (armedHit && bpMode == MODE_STEP)) begin
          stNxt = ST_WAIT;
          strobe.latchSel = 1'b1;
        end else if (armedHit && bpMode == MODE_TRAP) begin
          stNxt = ST_ACK;
          strobe.latchInject = 1'b1;
        end else if (armedHit && bpMode == MODE_BERR) begin
          stNxt = ST_BERR;
        end else begin
          stNxt = ST_ACK;
          strobe.latchSel = 1'b1;
        end
      end
      ST_WAIT: if (clearDbg || stepPress) stNxt = ST_ACK;
      ST_ACK: begin
        stNxt = ST_DONE;
        strobe.dropSel = 1'b1;
      end
      ST_BERR: begin
        stNxt = ST_DONE;
        strobe.dropSel = 1'b1;
      end
      ST_DONE: if (!busReq) stNxt = ST_IDLE;
      default: stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNxt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
      confQ <= 1'b0;
      holdQ <= 1'b0;
      ovlQ  <= 1'b1;
      bankQ <= 1'b0;
      modeQ <= MODE_OFF;
    end else if (clearDbg) begin
      pendQ <= 1'b0;
      confQ <= 1'b0;
      holdQ <= 1'b0;
      ovlQ  <= 1'b0;
      bankQ <= 1'b0;
      modeQ <= MODE_OFF;
    end else if (st == ST_IDLE && busReq) begin
      if (romRegion) begin
        ovlQ  <= 1'b0;
        bankQ <= 1'b0;
      end
      if (pendQ && vecRead) begin
        confQ <= 1'b1;
        pendQ <= 1'b0;
      end
      if (armedHit) begin
        pendQ <= 1'b1;
        confQ <= 1'b0;
        modeQ <= bpMode;
        if (bpMode == MODE_STEP) begin
          holdQ <= 1'b1;
        end else begin
          ovlQ  <= 1'b1;
          bankQ <= 1'b1;
        end
      end
    end
  end

  assign cycleAck     = (st == ST_ACK);
  assign busErr       = (st == ST_BERR);
  assign matchPending = pendQ;
  assign hitConfirmed = confQ;
  assign stepHold     = holdQ;
  assign overlayOn    = ovlQ;
  assign romBank      = bankQ;
  assign activeMode   = modeQ;
endmodule

// File: rtl/bus_bp_ctrl.sv
`timescale 1ns/1ps
module bus_bp_ctrl
  import bus_bp_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int ROM_NIB = 4,
  parameter int TRAP_VEC = 4,
  parameter int BERR_VEC = 2,
  parameter logic [DW-1:0] TRAP_OPCODE = 16'h4AFC
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busReq,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  input  logic [2:0]    funcCode,
  input  logic          bpLoad,
  input  logic [AW-1:0] bpAddrIn,
  input  logic [1:0]    bpMode,
  input  logic          stepPress,
  input  logic          clearDbg,
  output logic          cycleAck,
  output logic          busErr,
  output logic          ramSel,
  output logic          romSel,
  output logic          romBank,
  output logic          dataDrive,
  output logic [DW-1:0] dataOut,
  output logic          matchPending,
  output logic          hitConfirmed,
  output logic          stepHold,
  output logic          overlayOn,
  output logic [1:0]    activeMode
);
  dpStrobe_t strobe;
  logic      fetchHit;
  logic      romRegion;

  bus_bp_dp #(
    .AW(AW), .DW(DW), .ROM_NIB(ROM_NIB), .TRAP_OPCODE(TRAP_OPCODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .fcLow(funcCode[1:0]),
    .bpLoad(bpLoad), .bpAddrIn(bpAddrIn), .overlayOn(overlayOn),
    .strobe(strobe), .fetchHit(fetchHit), .romRegion(romRegion),
    .ramSel(ramSel), .romSel(romSel), .dataDrive(dataDrive), .dataOut(dataOut)
  );

  bus_bp_ctl #(
    .AW(AW), .TRAP_VEC(TRAP_VEC), .BERR_VEC(BERR_VEC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .funcCode(funcCode), .busAddr(busAddr), .fetchHit(fetchHit),
    .romRegion(romRegion), .bpMode(bpMode), .stepPress(stepPress),
    .clearDbg(clearDbg), .strobe(strobe), .cycleAck(cycleAck),
    .busErr(busErr), .matchPending(matchPending), .hitConfirmed(hitConfirmed),
    .stepHold(stepHold), .overlayOn(overlayOn), .romBank(romBank),
    .activeMode(activeMode)
  );
endmodule

// File: rtl/bus_bp_ctrl_chk.sv
`timescale 1ns/1ps
module bus_bp_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic cycleAck,
  input logic busErr,
  input logic ramSel,
  input logic romSel,
  input logic dataDrive,
  input logic matchPending,
  input logic hitConfirmed,
  input logic stepHold,
  input logic stepPress,
  input logic clearDbg
);
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    cycleAck |=> !cycleAck);

  p_sel_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(ramSel && romSel));

  p_inject_deselect_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataDrive |-> (!ramSel && !romSel));

  p_berr_alone_r8: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (!cycleAck && !ramSel && !romSel));

  p_confirm_after_pending_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hitConfirmed) |-> $past(matchPending));

  p_step_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cycleAck) && $past(stepHold)) |-> ($past(stepPress) || $past(clearDbg)));
endmodule

bind bus_bp_ctrl bus_bp_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .cycleAck(cycleAck), .busErr(busErr),
  .ramSel(ramSel), .romSel(romSel), .dataDrive(dataDrive),
  .matchPending(matchPending), .hitConfirmed(hitConfirmed),
  .stepHold(stepHold), .stepPress(stepPress), .clearDbg(clearDbg)
);

// File: tb/bus_bp_ctrl_test.sv
`timescale 1ns/1ps
module bus_bp_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0;
  logic        busWrite = 1'b0;
  logic [23:0] busAddr = '0;
  logic [2:0]  funcCode = '0;
  logic        bpLoad = 1'b0;
  logic [23:0] bpAddrIn = '0;
  logic [1:0]  bpMode = '0;
  logic        stepPress = 1'b0;
  logic        clearDbg = 1'b0;
  logic        cycleAck, busErr, ramSel, romSel, romBank, dataDrive;
  logic [15:0] dataOut;
  logic        matchPending, hitConfirmed, stepHold, overlayOn;
  logic [1:0]  activeMode;

  typedef struct packed {
    logic        err;
    logic        ram;
    logic        rom;
    logic        bank;
    logic        drv;
    logic [15:0] data;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    compared = 0;
  int    mismatched = 0;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  bus_bp_ctrl uut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .funcCode(funcCode), .bpLoad(bpLoad),
    .bpAddrIn(bpAddrIn), .bpMode(bpMode), .stepPress(stepPress),
    .clearDbg(clearDbg), .cycleAck(cycleAck), .busErr(busErr),
    .ramSel(ramSel), .romSel(romSel), .romBank(romBank),
    .dataDrive(dataDrive), .dataOut(dataOut), .matchPending(matchPending),
    .hitConfirmed(hitConfirmed), .stepHold(stepHold), .overlayOn(overlayOn),
    .activeMode(activeMode)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: every cycle termination must match the oldest expected item
  always @(negedge clk) begin
    if (rstN && !done && (cycleAck || busErr)) begin
      exp_t got;
      got = '{err: busErr, ram: ramSel, rom: romSel, bank: romBank,
              drv: dataDrive, data: dataOut};
      if (expQ.size() == 0) begin
        compared++;
        mismatched++;
        $display("FAIL unexpected termination: got %h expected none", got);
      end else begin
        exp_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, 32'(got), 32'(e));
      end
    end
  end

  task automatic waitEnd();
    int t = 0;
    while (!(cycleAck || busErr) && t < 20) begin
      @(negedge clk);
      t++;
    end
    if (t >= 20) begin
      compared++;
      mismatched++;
      $display("FAIL cycle timeout: got no termination expected one");
    end
    busReq = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doCycle(input logic [23:0] a, input logic [2:0] fc,
                         input logic wr, input exp_t e, input string tag);
    @(negedge clk);
    busAddr = a; funcCode = fc; busWrite = wr; busReq = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(tag);
    waitEnd();
  endtask

  // held cycle released by a step press or by a clear
  task automatic heldCycle(input logic [23:0] a, input bit useClear,
                           input exp_t e, input string tag);
    @(negedge clk);
    busAddr = a; funcCode = 3'b110; busWrite = 1'b0; busReq = 1'b1;
    repeat (4) @(negedge clk);
    chk({tag, " hold"}, 32'(stepHold), 32'd1);
    chk({tag, " no ack while held"}, 32'(cycleAck), 32'd0);
    expQ.push_back(e);
    tagQ.push_back(tag);
    if (useClear) clearDbg = 1'b1; else stepPress = 1'b1;
    @(negedge clk);
    clearDbg = 1'b0;
    stepPress = 1'b0;
    waitEnd();
  endtask

  task automatic pulseClear();
    @(negedge clk); clearDbg = 1'b1;
    @(negedge clk); clearDbg = 1'b0;
  endtask

  function automatic exp_t mk(input logic err, ram, rom, bank, drv, input logic [15:0] d);
    return '{err: err, ram: ram, rom: rom, bank: bank, drv: drv, data: d};
  endfunction

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: got hang expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 overlay", 32'(overlayOn), 32'd1);
    chk("R1 bank", 32'(romBank), 32'd0);
    chk("R1 ack/err", 32'({cycleAck, busErr}), 32'd0);
    chk("R1 flags", 32'({matchPending, hitConfirmed, stepHold}), 32'd0);
    chk("R1 mode", 32'(activeMode), 32'd0);

    // R3 boot overlay, then cleared by ROM region access; R2 decode
    doCycle(24'h000000, 3'b110, 1'b0, mk(0,0,1,0,0,16'h0), "R3 overlay low->ROM");
    chk("R3 overlay kept", 32'(overlayOn), 32'd1);
    doCycle(24'h400100, 3'b110, 1'b0, mk(0,0,1,0,0,16'h0), "R2 ROM region");
    chk("R3 overlay cleared", 32'(overlayOn), 32'd0);
    doCycle(24'h000004, 3'b101, 1'b0, mk(0,1,0,0,0,16'h0), "R3 low->RAM");

    // load breakpoint, trap mode
    @(negedge clk); bpAddrIn = 24'h001234; bpLoad = 1'b1; bpMode = 2'd2;
    @(negedge clk); bpLoad = 1'b0; bpAddrIn = 24'h0;
    // R4 data accesses do not match
    doCycle(24'h001234, 3'b001, 1'b0, mk(0,1,0,0,0,16'h0), "R4 data read");
    doCycle(24'h001234, 3'b101, 1'b1, mk(0,1,0,0,0,16'h0), "R4 data write");
    chk("R4 pending after data", 32'(matchPending), 32'd0);

    // R7 trap injection
    doCycle(24'h001234, 3'b110, 1'b0, mk(0,0,0,1,1,16'h4AFC), "R7 trap inject");
    chk("R9 pending", 32'(matchPending), 32'd1);
    chk("R9 overlay back", 32'(overlayOn), 32'd1);
    chk("R9 bank", 32'(romBank), 32'd1);
    chk("R12 mode trap", 32'(activeMode), 32'd2);
    // R10 non-vector read does not confirm
    doCycle(24'h000020, 3'b101, 1'b0, mk(0,0,1,1,0,16'h0), "R9 debug bank read");
    chk("R10 not confirmed", 32'({hitConfirmed, matchPending}), 32'b01);
    doCycle(24'h000010, 3'b101, 1'b0, mk(0,0,1,1,0,16'h0), "R9 vector fetch");
    chk("R10 confirmed", 32'({hitConfirmed, matchPending}), 32'b10);
    // R11 clear
    pulseClear();
    chk("R11 flags", 32'({matchPending, hitConfirmed, stepHold, overlayOn, romBank}), 32'd0);
    chk("R11 mode", 32'(activeMode), 32'd0);

    // R8 bus error mode, user program fetch
    @(negedge clk); bpMode = 2'd3;
    doCycle(24'h001234, 3'b010, 1'b0, mk(1,0,0,1,0,16'h0), "R8 bus error");
    chk("R12 mode berr", 32'(activeMode), 32'd3);
    chk("R9 pending berr", 32'({matchPending, overlayOn}), 32'b11);
    doCycle(24'h000010, 3'b101, 1'b0, mk(0,0,1,1,0,16'h0), "R10 wrong vector");
    chk("R10 wrong vector no confirm", 32'(hitConfirmed), 32'd0);
    doCycle(24'h000008, 3'b101, 1'b0, mk(0,0,1,1,0,16'h0), "R10 berr vector");
    chk("R10 berr confirmed", 32'({hitConfirmed, matchPending}), 32'b10);
    pulseClear();

    // R6 press with nothing held
    @(negedge clk); stepPress = 1'b1;
    @(negedge clk); stepPress = 1'b0;
    @(negedge clk);
    chk("R6 no ack", 32'(cycleAck), 32'd0);
    chk("R6 flags", 32'({stepHold, matchPending, activeMode}), 32'd0);
    doCycle(24'h000100, 3'b110, 1'b0, mk(0,1,0,0,0,16'h0), "R6 normal after press");

    // R4 mode off: fetch of bp address is normal
    @(negedge clk); bpMode = 2'd0;
    doCycle(24'h001234, 3'b110, 1'b0, mk(0,1,0,0,0,16'h0), "R4 mode off");
    chk("R4 off no pending", 32'(matchPending), 32'd0);

    // R5 single step
    @(negedge clk); bpMode = 2'd1;
    heldCycle(24'h001234, 1'b0, mk(0,1,0,0,0,16'h0), "R5 step first");
    chk("R12 mode step", 32'(activeMode), 32'd1);
    chk("R5 pending", 32'(matchPending), 32'd1);
    heldCycle(24'h001236, 1'b0, mk(0,1,0,0,0,16'h0), "R5 step second");
    heldCycle(24'h001238, 1'b1, mk(0,1,0,0,0,16'h0), "R11 clear releases");
    chk("R11 hold cleared", 32'({stepHold, matchPending}), 32'd0);
    @(negedge clk); bpMode = 2'd0;
    doCycle(24'h001240, 3'b110, 1'b0, mk(0,1,0,0,0,16'h0), "R2 free run");
    chk("R2 queue drained", 32'(expQ.size()), 32'd0);

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule